// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the configuration state that governs system-management memory and, for each memory access it is shown, decides which backing should serve it. It has no storage array of its own. It turns an access address and a flag that marks system-management-mode (SMM) accesses into one of three routes:

- the default decode path (PCI);
- RAM, together with the RAM address to use;
- a blackhole, which returns all ones on reads and discards writes.

Three address regions are controlled:

- the legacy window at 0x000A0000–0x000BFFFF;
- a high alias of that window at 0xFEDA0000–0xFEDBFFFF;
- a TSEG region at the top of below-4G memory.

Software programs a main control register, an extended control register and a 16-bit TSEG size query word through a simple write port, and reads all three back at all times. Setting the lock bit freezes both control registers until reset and forces the open bit off. The route for an access presented in one cycle appears on the outputs one clock later.

Top module: `smram_route_ctrl`

## Requirements
- R1: After reset the main control reads 0x00, the extended control reads 0x00, the size query word reads 0xFFFF (when the extended size parameter is nonzero, default 16), and route_vld is 0.
- R2: The main control (select 0, wdata[7:0]) holds open at bit 0, lock at bit 1 and global enable at bit 2. The extended control (select 1) holds TSEG enable at bit 0, the size code at bits 2:1 and high enable at bit 3. While unlocked only these bits are writable and all other bits read 0. A write with select 3 changes nothing.
- R3: A main-control write that leaves lock set also clears open in that same update. Lock is sticky. Once lock is set, writes to either control register have no effect until reset.
- R4: For a non-SMM access in the legacy window, the route is RAM when open=1 and high enable=0, and PCI otherwise.
- R5: For an SMM access in the legacy window, the route is RAM when high enable=0 and either global enable or open is 1, and PCI otherwise.
- R6: An access in the high alias is routed to RAM when high enable=1 and either open=1 or (SMM and global enable=1). In that case route_addr is the address minus 0xFEDA0000 plus 0x000A0000. Otherwise the route is PCI with the address unchanged.
- R7: Size code 0, 1, 2 and 3 select a TSEG of 1 MB, 2 MB, 8 MB and the extended size (default 16 MB) respectively. TSEG spans from LOW_MEM_TOP minus that size up to LOW_MEM_TOP, exclusive, and is absent when TSEG enable is 0.
- R8: A non-SMM access inside TSEG gets route blackhole with route_rdata 0xFFFFFFFF. An SMM access inside TSEG gets route RAM.
- R9: A write with select 2 stores wdata. If the stored value is 0xFFFF and the extended size is nonzero, the word reads back the configured megabyte count instead.
- R10: route_code is one-hot: 3'b001 PCI, 3'b010 RAM, 3'b100 blackhole. An access held in cycle N is reported with route_vld=1 after the next clock edge only. route_rdata is 0 for any route other than blackhole. Addresses outside the three regions route to PCI unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 main control, 1 extended control, 2 size query word |
| cfg_wdata_i | input | 16 | Write data; control registers take bits 7:0 |
| ctl_rd_o | output | 8 | Main control readback |
| xctl_rd_o | output | 8 | Extended control readback |
| tseg_mb_rd_o | output | 16 | Size query word readback |
| acc_valid_i | input | 1 | Access presented this cycle |
| acc_addr_i | input | 32 | Access address |
| acc_smm_i | input | 1 | Access is issued in system-management mode |
| route_vld_o | output | 1 | Route outputs describe the access of the previous cycle |
| route_code_o | output | 3 | One-hot route: 001 PCI, 010 RAM, 100 blackhole |
| route_addr_o | output | 32 | Address to use on the chosen backing |
| route_rdata_o | output | 32 | Read data supplied by the blackhole |

## Verification
The bench aims at the asymmetric mix of open and high enable. A design that tied the high alias to open alone would leak the alias to non-SMM accesses while the legacy window is still open to everyone. It probes the TSEG edges (base minus one, base, top minus one, top) for every size code, where an off-by-one compare would black-hole a RAM byte or expose a protected one. It locks with open requested in the same write, so a design that clears open only on a later update shows open still set. It also writes the query value twice to make sure the substitution is applied on every write and not only the first.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int unsigned AW  = 32;
  localparam int unsigned RW  = 8;
  localparam int unsigned MBW = 16;

  typedef enum logic [2:0] {
    ROUTE_PCI  = 3'b001,
    ROUTE_RAM  = 3'b010,
    ROUTE_HOLE = 3'b100
  } route_e;

  localparam logic [AW-1:0] LEGACY_BASE  = 32'h000A_0000;
  localparam logic [AW-1:0] WINDOW_BYTES = 32'h0002_0000;
  localparam logic [AW-1:0] HIGH_BASE    = 32'hFEDA_0000;

  localparam int unsigned CTL_OPEN = 0;
  localparam int unsigned CTL_LOCK = 1;
  localparam int unsigned CTL_GEN  = 2;
  localparam int unsigned XC_TEN   = 0;
  localparam int unsigned XC_SZ_LO = 1;
  localparam int unsigned XC_HEN   = 3;

  localparam logic [RW-1:0] CTL_MASK_FREE = 8'h07;
  localparam logic [RW-1:0] CTL_MASK_LCK  = 8'h00;
  localparam logic [RW-1:0] XC_MASK_FREE  = 8'h0F;
  localparam logic [RW-1:0] XC_MASK_LCK   = 8'h00;

  localparam logic [MBW-1:0] TSEG_QUERY = 16'hFFFF;

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_XC  = 2'd1;
  localparam logic [1:0] SEL_MB  = 2'd2;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
#(
  parameter int unsigned EXT_TSEG_MB = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [1:0]     sel_i,
  input  logic [MBW-1:0] wdata_i,
  output logic [RW-1:0]  ctl_o,
  output logic [RW-1:0]  xc_o,
  output logic [MBW-1:0] mb_o
);
  localparam logic [MBW-1:0] MB_RST = (EXT_TSEG_MB > 0) ? TSEG_QUERY : '0;
  localparam logic [MBW-1:0] MB_CFG = MBW'(EXT_TSEG_MB);

  logic [RW-1:0]  ctl_q, ctl_d, xc_q, xc_d, ctl_mask, xc_mask;
  logic [MBW-1:0] mb_q, mb_d;
  logic           ctl_en, xc_en, mb_en;

  assign ctl_en   = we_i && (sel_i == SEL_CTL);
  assign xc_en    = we_i && (sel_i == SEL_XC);
  assign mb_en    = we_i && (sel_i == SEL_MB);
  assign ctl_mask = ctl_q[CTL_LOCK] ? CTL_MASK_LCK : CTL_MASK_FREE;
  assign xc_mask  = ctl_q[CTL_LOCK] ? XC_MASK_LCK  : XC_MASK_FREE;

  always_comb begin
    ctl_d = (ctl_q & ~ctl_mask) | (wdata_i[RW-1:0] & ctl_mask);
    if (ctl_d[CTL_LOCK]) ctl_d[CTL_OPEN] = 1'b0;
    xc_d = (xc_q & ~xc_mask) | (wdata_i[RW-1:0] & xc_mask);
    mb_d = wdata_i;
    if ((EXT_TSEG_MB > 0) && (wdata_i == TSEG_QUERY)) mb_d = MB_CFG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      xc_q  <= '0;
      mb_q  <= MB_RST;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (xc_en)  xc_q  <= xc_d;
      if (mb_en)  mb_q  <= mb_d;
    end
  end

  assign ctl_o = ctl_q;
  assign xc_o  = xc_q;
  assign mb_o  = mb_q;

  // R3: lock never drops while out of reset
  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[CTL_LOCK] |=> ctl_q[CTL_LOCK]);
  // R3: locked registers ignore writes
  assert_locked_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[CTL_LOCK] && we_i) |=> ($stable(ctl_q) && $stable(xc_q)));
  // R3: open cannot coexist with lock
  assert_lock_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_en |=> !(ctl_q[CTL_LOCK] && ctl_q[CTL_OPEN]));
  // R9: query write returns configured size
  assert_query_answer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((EXT_TSEG_MB > 0) && mb_en && (wdata_i == TSEG_QUERY)) |=> (mb_q == MB_CFG));
endmodule

// File: rtl/smram_tseg_size.sv
module smram_tseg_size
  import smram_pkg::*;
#(
  parameter int unsigned      EXT_TSEG_MB = 16,
  parameter logic [AW-1:0]    LOW_MEM_TOP = 32'h8000_0000
) (
  input  logic          ten_i,
  input  logic [1:0]    code_i,
  output logic          active_o,
  output logic [AW-1:0] base_o
);
  localparam int unsigned MB_SHIFT = 20;
  localparam logic [AW-1:0] EXT_BYTES = AW'(EXT_TSEG_MB) << MB_SHIFT;

  logic [AW-1:0] size;

  always_comb begin
    unique case (code_i)
      2'd0:    size = AW'(1) << MB_SHIFT;
      2'd1:    size = AW'(2) << MB_SHIFT;
      2'd2:    size = AW'(8) << MB_SHIFT;
      default: size = EXT_BYTES;
    endcase
  end

  assign active_o = ten_i && (size != '0) && (size <= LOW_MEM_TOP);
  assign base_o   = LOW_MEM_TOP - size;

  // R7: an active region always lies below the top of low memory
  always_comb begin
    assert_tseg_below_top_R7: assert (!active_o || (base_o < LOW_MEM_TOP));
  end
endmodule

// File: rtl/smram_route_dec.sv
module smram_route_dec
  import smram_pkg::*;
#(
  parameter logic [AW-1:0] LOW_MEM_TOP = 32'h8000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          gen_i,
  input  logic          hen_i,
  input  logic          tseg_active_i,
  input  logic [AW-1:0] tseg_base_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          acc_smm_i,
  output logic          route_vld_o,
  output logic [2:0]    route_code_o,
  output logic [AW-1:0] route_addr_o,
  output logic [AW-1:0] route_rdata_o
);
  logic          in_leg, in_high, in_tseg, priv;
  route_e        code_d;
  logic [AW-1:0] addr_d, rdata_d;
  logic          vld_q;
  logic [2:0]    code_q;
  logic [AW-1:0] addr_q, rdata_q;

  always_comb begin
    in_leg  = (acc_addr_i >= LEGACY_BASE) && (acc_addr_i < LEGACY_BASE + WINDOW_BYTES);
    in_high = (acc_addr_i >= HIGH_BASE) && (acc_addr_i < HIGH_BASE + WINDOW_BYTES);
    in_tseg = tseg_active_i && (acc_addr_i >= tseg_base_i) && (acc_addr_i < LOW_MEM_TOP);
    priv    = open_i || (acc_smm_i && gen_i);
    code_d  = ROUTE_PCI;
    addr_d  = acc_addr_i;
    if (in_leg) begin
      if (!hen_i && priv) code_d = ROUTE_RAM;
    end else if (in_high) begin
      if (hen_i && priv) begin
        code_d = ROUTE_RAM;
        addr_d = acc_addr_i - HIGH_BASE + LEGACY_BASE;
      end
    end else if (in_tseg) begin
      code_d = acc_smm_i ? ROUTE_RAM : ROUTE_HOLE;
    end
    rdata_d = (code_d == ROUTE_HOLE) ? '1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      code_q  <= ROUTE_PCI;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      vld_q <= acc_valid_i;
      if (acc_valid_i) begin
        code_q  <= code_d;
        addr_q  <= addr_d;
        rdata_q <= rdata_d;
      end
    end
  end

  assign route_vld_o   = vld_q;
  assign route_code_o  = code_q;
  assign route_addr_o  = addr_q;
  assign route_rdata_o = rdata_q;

  // R10: exactly one route bit when valid
  assert_route_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_vld_o |-> ($countones(route_code_o) == 1));
  // R10: valid follows the request by one edge
  assert_route_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> route_vld_o);
  // R8: non-SMM TSEG hit is black-holed with all-ones data
  assert_tseg_hole_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_smm_i && in_tseg) |=>
      ((route_code_o == ROUTE_HOLE) && (route_rdata_o == '1)));
  // R6: without high enable the alias never reaches RAM
  assert_high_hidden_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && in_high && !hen_i) |=> (route_code_o != ROUTE_RAM));
endmodule

// File: rtl/smram_route_ctrl.sv
module smram_route_ctrl
  import smram_pkg::*;
#(
  parameter int unsigned   EXT_TSEG_MB = 16,
  parameter logic [31:0]   LOW_MEM_TOP = 32'h8000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [7:0]  ctl_rd_o,
  output logic [7:0]  xctl_rd_o,
  output logic [15:0] tseg_mb_rd_o,
  input  logic        acc_valid_i,
  input  logic [31:0] acc_addr_i,
  input  logic        acc_smm_i,
  output logic        route_vld_o,
  output logic [2:0]  route_code_o,
  output logic [31:0] route_addr_o,
  output logic [31:0] route_rdata_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_int;
  logic [RW-1:0] ctl, xc;
  logic          tseg_active;
  logic [AW-1:0] tseg_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  smram_cfg_regs #(.EXT_TSEG_MB(EXT_TSEG_MB)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .ctl_o   (ctl),
    .xc_o    (xc),
    .mb_o    (tseg_mb_rd_o)
  );

  smram_tseg_size #(.EXT_TSEG_MB(EXT_TSEG_MB), .LOW_MEM_TOP(LOW_MEM_TOP)) u_tseg (
    .ten_i    (xc[XC_TEN]),
    .code_i   (xc[XC_SZ_LO+1:XC_SZ_LO]),
    .active_o (tseg_active),
    .base_o   (tseg_base)
  );

  smram_route_dec #(.LOW_MEM_TOP(LOW_MEM_TOP)) u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_int),
    .open_i        (ctl[CTL_OPEN]),
    .gen_i         (ctl[CTL_GEN]),
    .hen_i         (xc[XC_HEN]),
    .tseg_active_i (tseg_active),
    .tseg_base_i   (tseg_base),
    .acc_valid_i   (acc_valid_i),
    .acc_addr_i    (acc_addr_i),
    .acc_smm_i     (acc_smm_i),
    .route_vld_o   (route_vld_o),
    .route_code_o  (route_code_o),
    .route_addr_o  (route_addr_o),
    .route_rdata_o (route_rdata_o)
  );

  assign ctl_rd_o  = ctl;
  assign xctl_rd_o = xc;
endmodule

// File: tb/tb_smram_route_ctrl.sv
`timescale 1ns/1ps
module tb_smram_route_ctrl;
  localparam logic [31:0] TOP    = 32'h8000_0000;
  localparam logic [31:0] LEG    = 32'h000A_0000;
  localparam logic [31:0] HIGH   = 32'hFEDA_0000;
  localparam logic [31:0] WIN    = 32'h0002_0000;
  localparam int unsigned EXT_MB = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic [7:0]  ctl_rd, xctl_rd;
  logic [15:0] mb_rd;
  logic        acc_valid, acc_smm;
  logic [31:0] acc_addr;
  logic        route_vld;
  logic [2:0]  route_code;
  logic [31:0] route_addr, route_rdata;

  int nchecks = 0;
  int nerr = 0;
  bit done = 0;

  logic [7:0]  m_ctl, m_xc;
  logic [15:0] m_mb;

  always #2 clk = ~clk;

  smram_route_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .ctl_rd_o(ctl_rd), .xctl_rd_o(xctl_rd),
    .tseg_mb_rd_o(mb_rd), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_smm_i(acc_smm), .route_vld_o(route_vld), .route_code_o(route_code),
    .route_addr_o(route_addr), .route_rdata_o(route_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tseg_bytes(input logic [1:0] c);
    case (c)
      2'd0: return 32'h0010_0000;
      2'd1: return 32'h0020_0000;
      2'd2: return 32'h0080_0000;
      default: return EXT_MB * 32'h0010_0000;
    endcase
  endfunction

  function automatic void exp_route(input logic [31:0] a, input logic s,
                                    output logic [2:0] c, output logic [31:0] ra);
    logic open, gen, hen, priv;
    logic [31:0] base;
    open = m_ctl[0]; gen = m_ctl[2]; hen = m_xc[3];
    priv = open || (s && gen);
    base = TOP - tseg_bytes(m_xc[2:1]);
    c = 3'b001; ra = a;
    if (a >= LEG && a < LEG + WIN) begin
      if (!hen && priv) c = 3'b010;
    end else if (a >= HIGH && a < HIGH + WIN) begin
      if (hen && priv) begin c = 3'b010; ra = a - HIGH + LEG; end
    end else if (m_xc[0] && a >= base && a < TOP) begin
      c = s ? 3'b010 : 3'b100;
    end
  endfunction

  function automatic string region_tag(input logic [31:0] a, input logic s);
    if (a >= LEG && a < LEG + WIN) return s ? "R5" : "R4";
    if (a >= HIGH && a < HIGH + WIN) return "R6";
    if (m_xc[0] && a >= TOP - tseg_bytes(m_xc[2:1]) && a < TOP) return "R8";
    return "R10";
  endfunction

  task automatic model_reset();
    m_ctl = 8'h00; m_xc = 8'h00; m_mb = 16'hFFFF;
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: if (!m_ctl[1]) begin
              m_ctl = d[7:0] & 8'h07;
              if (m_ctl[1]) m_ctl[0] = 1'b0;
            end
      2'd1: if (!m_ctl[1]) m_xc = d[7:0] & 8'h0F;
      2'd2: m_mb = (d == 16'hFFFF) ? 16'(EXT_MB) : d;
      default: ;
    endcase
  endtask

  task automatic check_regs(input string req);
    chk(req, "main control", {24'h0, ctl_rd}, {24'h0, m_ctl});
    chk(req, "extended control", {24'h0, xctl_rd}, {24'h0, m_xc});
    chk(req, "size word", {16'h0, mb_rd}, {16'h0, m_mb});
  endtask

  task automatic do_access(input logic [31:0] a, input logic s, input string req);
    logic [2:0]  ec;
    logic [31:0] ea;
    exp_route(a, s, ec, ea);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_smm = s;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(req, "route valid", {31'h0, route_vld}, 32'h1);
    chk(req, "route code", {29'h0, route_code}, {29'h0, ec});
    chk(req, "route addr", route_addr, ea);
    chk(req, "route rdata", route_rdata, (ec == 3'b100) ? 32'hFFFF_FFFF : 32'h0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 5)
      0: return LEG + ($urandom % WIN);
      1: return HIGH + ($urandom % WIN);
      2: return TOP - 32'h1 - ($urandom % 32'h0180_0000);
      3: return TOP + ($urandom % 16);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] b;
    void'($urandom(32'h5EED));
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_valid = 0; acc_addr = 0; acc_smm = 0;
    apply_reset();

    // R1 reset state
    check_regs("R1");
    chk("R1", "route valid at reset", {31'h0, route_vld}, 32'h0);

    // R9 query word
    do_write(2'd2, 16'h1234); check_regs("R9");
    do_write(2'd2, 16'hFFFF); check_regs("R9");
    do_write(2'd2, 16'hFFFF); check_regs("R9");

    // R2 masks and ignored select
    do_write(2'd0, 16'h00FD); check_regs("R2");
    do_write(2'd1, 16'h00F6); check_regs("R2");
    do_write(2'd3, 16'hFFFF); check_regs("R2");

    // R4 R5 R6 directed mixes of open / global / high enable
    for (int k = 0; k < 8; k++) begin
      do_write(2'd0, {13'h0, k[1], 1'b0, k[0]});
      do_write(2'd1, {12'h0, k[2], 3'b000});
      do_access(LEG, 1'b0, "R4");
      do_access(LEG + WIN - 1, 1'b1, "R5");
      do_access(HIGH + 32'h123, 1'b0, "R6");
      do_access(HIGH + WIN - 1, 1'b1, "R6");
      do_access(LEG + WIN, 1'b0, "R10");
    end

    // R7 R8 TSEG edges for every size code
    do_write(2'd0, 16'h0004);
    for (int c = 0; c < 4; c++) begin
      do_write(2'd1, {13'h0, c[1:0], 1'b1});
      b = TOP - tseg_bytes(c[1:0]);
      do_access(b - 1, 1'b0, "R7");
      do_access(b, 1'b0, "R8");
      do_access(b, 1'b1, "R8");
      do_access(TOP - 1, 1'b0, "R8");
      do_access(TOP, 1'b0, "R7");
    end
    do_write(2'd1, 16'h0006);
    do_access(TOP - 1, 1'b0, "R7");

    // R10 valid drops after the access cycle
    @(negedge clk);
    chk("R10", "route valid idle", {31'h0, route_vld}, 32'h0);

    // Random mix
    for (int i = 0; i < 800; i++) begin
      if ($urandom % 4 == 0) begin
        logic [15:0] d;
        logic [1:0]  s;
        d = 16'($urandom);
        s = 2'($urandom);
        if (s == 2'd0) d[1] = 1'b0;
        do_write(s, d);
        check_regs(s == 2'd2 ? "R9" : "R2");
      end else begin
        logic [31:0] a;
        logic        sm;
        a = pick_addr();
        sm = 1'($urandom);
        do_access(a, sm, region_tag(a, sm));
      end
    end

    // R3 lock
    do_write(2'd1, 16'h0000);
    do_write(2'd0, 16'h0005);
    do_write(2'd0, 16'h0007);
    check_regs("R3");
    chk("R3", "open cleared by lock", {31'h0, ctl_rd[0]}, 32'h0);
    do_write(2'd0, 16'h0001); check_regs("R3");
    do_write(2'd1, 16'h000F); check_regs("R3");
    do_access(LEG + 32'h40, 1'b0, "R3");
    do_access(HIGH + 32'h40, 1'b0, "R3");
    apply_reset();
    check_regs("R3");
    do_write(2'd0, 16'h0001); check_regs("R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule